// File: doc/BRIEF.md
# Two-Stage Prescaled PWM Time-Base

This block produces two pulse-width-modulated outputs from one shared 16-bit time-base counter. The counter advances only on a tick made by two prescaler stages in series. The first stage divides the clock by a power of two. The second stage divides by 1 or by an even number from 2 to 14. The counter is compared against a period value and against one compare value per channel. Each output is a registered level derived from the counter and its compare value.

Software drives the block through a single-cycle write port and a combinational read port. A control word selects the two divide codes and the counting mode: up, down, up-down, or frozen. Separate registers hold the period and the two compare values. The counter itself can be read, and it can be loaded with any value; loading zero restarts the time base. A freshly reset block is frozen, so it runs only after software writes a running mode.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the control word reads 0x0003 (frozen, both divide codes 0). The period, both compare registers and the counter read 0, and both outputs are low.
- R2: Register addresses are 0 for control, 1 for period, 2 for compare A, 3 for compare B and 4 for the counter. In the control word the first-stage code sits at bits 12:10, the second-stage code at bits 9:7 and the mode at bits 1:0. All other control bits read 0. Period and compare registers read back the value written.
- R3: The counter steps once every D1*D2 clock cycles, where D1 = 2^code1 and D2 = 1, 2, 4, 6, 8, 10, 12, 14 for code2 = 0..7. It never steps between ticks.
- R4: A control write clears both prescaler stages, and the counter does not step on that edge. The first step after the write comes exactly D1*D2 cycles after the write edge.
- R5: Mode 0 (up): each tick adds 1. A counter at or above the period goes to 0 instead.
- R6: Mode 1 (down): each tick subtracts 1. A counter at 0 reloads the period value instead.
- R7: Mode 2 (up-down): the counter counts up, turns at the period and steps down, then turns at 0 and steps up. A control write sets the direction back to up.
- R8: Mode 3 (frozen): the counter and both outputs hold their values. Returning to a running mode resumes counting from the held value.
- R9: Writing the counter register loads the written value on that edge, overriding any tick, and sets the direction to up. Writing zero restarts the time base at 0.
- R10: When not frozen, each output changes on the same edge as the counter and follows its compare value C: low if C is 0, high if C is at least the period, otherwise high exactly while the counter is below C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The counter and both outputs are registered on the clock edge that takes a tick or a write, so a reference model advances on that same edge. A monitor compares against the model one nanosecond after every rising edge, once all registers have settled. Read data is combinational, so register readback is checked within the cycle that follows the write edge. The first step after a control write lands D1*D2 cycles after that write. Directed checks count falling edges from the write to the first visible change, and from that change to the next, and expect exactly D1*D2 edges in each case.

// File: rtl/pwmtb_pkg.sv
`timescale 1ns/1ps
package pwmtb_pkg;
    parameter int CNT_W  = 16;
    parameter int CODE_W = 3;
    parameter int ADDR_W = 3;
    parameter int NCH    = 2;

    localparam int S1_W   = (1 << CODE_W) - 1;
    localparam int S2_W   = CODE_W + 1;
    localparam int P1_LSB = 10;
    localparam int P2_LSB = 7;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_FRZ  = 2'd3
    } cmode_e;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PRD  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CMPA = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CMPB = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);

    // last count value of the power-of-two stage: 2^code - 1
    function automatic logic [S1_W-1:0] s1_last(input logic [CODE_W-1:0] code);
        logic [S1_W-1:0] r;
        for (int i = 0; i < S1_W; i++) r[i] = (i < int'(code));
        return r;
    endfunction

    // last count value of the even stage: ratio 1 for code 0, else 2*code
    function automatic logic [S2_W-1:0] s2_last(input logic [CODE_W-1:0] code);
        logic [S2_W-1:0] t;
        t = {code, 1'b0};
        return (code == '0) ? '0 : t - 1'b1;
    endfunction
endpackage

// File: rtl/pwmtb_prescale.sv
`timescale 1ns/1ps
module pwmtb_prescale
    import pwmtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CODE_W-1:0] code1,
    input  logic [CODE_W-1:0] code2,
    output logic              tick
);
    typedef struct packed {
        logic [S1_W-1:0] s1;
        logic [S2_W-1:0] s2;
    } pst_t;

    pst_t st_q, st_d;
    logic s1_wrap, s2_wrap;

    always_comb begin
        s1_wrap = (st_q.s1 >= s1_last(code1));
        s2_wrap = (st_q.s2 >= s2_last(code2));
        tick    = s1_wrap && s2_wrap && !clr;
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else if (s1_wrap) begin
            st_d.s1 = '0;
            st_d.s2 = s2_wrap ? '0 : st_q.s2 + 1'b1;
        end else begin
            st_d.s1 = st_q.s1 + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwmtb_count.sv
`timescale 1ns/1ps
module pwmtb_count
    import pwmtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             dir_clr,
    input  cmode_e           mode,
    input  logic [CNT_W-1:0] prd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dn;
    } cst_t;

    cst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
            st_d.dn  = 1'b0;
        end else if (dir_clr) begin
            st_d.dn = 1'b0;
        end else if (tick) begin
            unique case (mode)
                MODE_UP:   st_d.cnt = (st_q.cnt >= prd) ? '0 : st_q.cnt + 1'b1;
                MODE_DOWN: st_d.cnt = (st_q.cnt == '0) ? prd : st_q.cnt - 1'b1;
                MODE_UPDN: begin
                    if (!st_q.dn) begin
                        if (st_q.cnt >= prd) begin
                            st_d.dn  = 1'b1;
                            st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.dn  = 1'b0;
                            st_d.cnt = (prd == '0) ? '0 : CNT_W'(1);
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

    // R3
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(st_q.cnt));
    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP && tick && !load && st_q.cnt >= prd) |=> (st_q.cnt == '0));
    // R6
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN && tick && !load && st_q.cnt == '0) |=> (st_q.cnt == $past(prd)));
    // R7
    updn_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDN && tick && !load && !st_q.dn && prd != '0 && st_q.cnt >= prd) |=> st_q.dn);
    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FRZ && !load) |=> $stable(st_q.cnt));
    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(load_val) && !st_q.dn));
endmodule

// File: rtl/pwmtb_chan.sv
`timescale 1ns/1ps
module pwmtb_chan
    import pwmtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [CNT_W-1:0] prd_nx,
    input  logic [CNT_W-1:0] cmp_nx,
    output logic             pwm
);
    typedef struct packed {
        logic out;
    } ost_t;

    ost_t st_q, st_d;
    logic level;

    always_comb begin
        if (cmp_nx == '0)          level = 1'b0;
        else if (cmp_nx >= prd_nx) level = 1'b1;
        else                       level = (cnt_nx < cmp_nx);
        st_d     = st_q;
        if (!hold) st_d.out = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.out;
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwmtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pwm_a,
    output logic              pwm_b
);
    typedef struct packed {
        logic [CODE_W-1:0]          p1;
        logic [CODE_W-1:0]          p2;
        logic [1:0]                 mode;
        logic [CNT_W-1:0]           prd;
        logic [NCH-1:0][CNT_W-1:0]  cmp;
    } rg_t;

    rg_t rg_q, rg_d;
    logic ctrl_wr, cnt_wr, tick;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [NCH-1:0]   pwm_vec;
    cmode_e mode_q, mode_d;

    always_comb begin
        rg_d    = rg_q;
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        cnt_wr  = wr_en && (wr_addr == A_CNT);
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    rg_d.p1   = wr_data[P1_LSB +: CODE_W];
                    rg_d.p2   = wr_data[P2_LSB +: CODE_W];
                    rg_d.mode = wr_data[1:0];
                end
                A_PRD:  rg_d.prd    = wr_data;
                A_CMPA: rg_d.cmp[0] = wr_data;
                A_CMPB: rg_d.cmp[1] = wr_data;
                default: ;
            endcase
        end
        mode_q = cmode_e'(rg_q.mode);
        mode_d = cmode_e'(rg_d.mode);
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[P1_LSB +: CODE_W] = rg_q.p1;
                rd_data[P2_LSB +: CODE_W] = rg_q.p2;
                rd_data[1:0]              = rg_q.mode;
            end
            A_PRD:  rd_data = rg_q.prd;
            A_CMPA: rd_data = rg_q.cmp[0];
            A_CMPB: rd_data = rg_q.cmp[1];
            A_CNT:  rd_data = cnt_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.mode <= MODE_FRZ;
        end else begin
            rg_q <= rg_d;
        end
    end

    pwmtb_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_wr),
        .code1 (rg_q.p1),
        .code2 (rg_q.p2),
        .tick  (tick)
    );

    pwmtb_count u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_wr),
        .dir_clr  (ctrl_wr),
        .mode     (mode_q),
        .prd      (rg_q.prd),
        .load_val (wr_data),
        .cnt_q_o  (cnt_q),
        .cnt_d_o  (cnt_d)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwmtb_chan u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (mode_d == MODE_FRZ),
            .cnt_nx (cnt_d),
            .prd_nx (rg_d.prd),
            .cmp_nx (rg_d.cmp[c]),
            .pwm    (pwm_vec[c])
        );

        // R10
        cmp_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rg_q.cmp[c] == '0 && mode_q != MODE_FRZ) |-> !pwm_vec[c]);
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];
endmodule

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd0;
    logic [15:0] rd_data;
    logic        pwm_a, pwm_b;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pwm_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    typedef struct { logic [15:0] cnt; logic a; logic b; } exp_t;
    exp_t exp_q[$];

    // reference model built from the requirements
    int          m_cc;
    logic [15:0] m_cnt, m_prd;
    logic [15:0] m_cmp [2];
    logic [2:0]  m_p1, m_p2;
    logic [1:0]  m_mode;
    logic        m_dn;
    logic        m_out [2];

    function automatic int ratio(input logic [2:0] p1, input logic [2:0] p2);
        int t2 [8] = '{1, 2, 4, 6, 8, 10, 12, 14};
        return (1 << p1) * t2[p2];
    endfunction

    function automatic logic lvl(input logic [15:0] c, input logic [15:0] p, input logic [15:0] k);
        if (k == 0) return 1'b0;
        if (k >= p) return 1'b1;
        return c < k;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cc = 0; m_cnt = 0; m_prd = 0; m_cmp[0] = 0; m_cmp[1] = 0;
            m_p1 = 0; m_p2 = 0; m_mode = 2'd3; m_dn = 0; m_out[0] = 0; m_out[1] = 0;
            exp_q.delete();
        end else begin
            bit cw, tk;
            exp_t e;
            cw = wr_en && wr_addr == 3'd0;
            tk = (m_cc == ratio(m_p1, m_p2) - 1) && !cw;
            if (cw || tk) m_cc = 0; else m_cc++;
            if (wr_en && wr_addr == 3'd4) begin m_cnt = wr_data; m_dn = 0; end
            else if (cw) m_dn = 0;
            else if (tk) begin
                case (m_mode)
                    2'd0: m_cnt = (m_cnt >= m_prd) ? 16'd0 : m_cnt + 16'd1;
                    2'd1: m_cnt = (m_cnt == 0) ? m_prd : m_cnt - 16'd1;
                    2'd2: if (!m_dn) begin
                              if (m_cnt >= m_prd) begin m_dn = 1; if (m_cnt != 0) m_cnt--; end
                              else m_cnt++;
                          end else begin
                              if (m_cnt == 0) begin m_dn = 0; if (m_prd != 0) m_cnt = 1; end
                              else m_cnt--;
                          end
                    default: ;
                endcase
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_p1 = wr_data[12:10]; m_p2 = wr_data[9:7]; m_mode = wr_data[1:0]; end
                    3'd1: m_prd = wr_data;
                    3'd2: m_cmp[0] = wr_data;
                    3'd3: m_cmp[1] = wr_data;
                    default: ;
                endcase
            end
            if (m_mode != 2'd3)
                for (int c = 0; c < 2; c++) m_out[c] = lvl(m_cnt, m_prd, m_cmp[c]);
            e.cnt = m_cnt; e.a = m_out[0]; e.b = m_out[1];
            exp_q.push_back(e);
        end
    end

    // monitor: pops one expected item per cycle after the edge settles
    always begin
        @(posedge clk);
        #1;
        if (rst_n && exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if ((rd_addr == 3'd4 && rd_data != e.cnt) || pwm_a != e.a || pwm_b != e.b) begin
                n_fail++;
                $display("FAIL %s scoreboard: cnt=%0d a=%0d b=%0d expected cnt=%0d a=%0d b=%0d",
                         cur_req, rd_data, pwm_a, pwm_b, e.cnt, e.a, e.b);
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ctl(input int p1, input int p2, input int md);
        return 16'((p1 << 10) | (p2 << 7) | md);
    endfunction

    // counts falling edges until rd_data changes; k-1 equals the edges elapsed
    task automatic wait_change(output int k);
        logic [15:0] s;
        s = rd_data;
        k = 1;
        while (rd_data == s && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_val(input logic [15:0] v);
        int n = 0;
        while (rd_data != v && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        logic [15:0] v;
        logic ha, hb;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", int'(rd_data), 3);
        check("R1 pwm_a", int'(pwm_a), 0);
        check("R1 pwm_b", int'(pwm_b), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctrl after release", int'(rd_data), 3);
        rd_addr = 3'd1; #0.1; check("R1 period", int'(rd_data), 0);
        rd_addr = 3'd4; #0.1; check("R1 counter", int'(rd_data), 0);

        // R2 field positions and readback
        cur_req = "R2";
        rd_addr = 3'd0;
        wr(3'd0, 16'hFFFF);
        check("R2 ctrl mask", int'(rd_data), 16'h1F83);
        wr(3'd1, 16'd9);  rd_addr = 3'd1; #0.1; check("R2 period", int'(rd_data), 9);
        wr(3'd2, 16'd4);  rd_addr = 3'd2; #0.1; check("R2 cmpA", int'(rd_data), 4);
        wr(3'd3, 16'd20); rd_addr = 3'd3; #0.1; check("R2 cmpB", int'(rd_data), 20);
        rd_addr = 3'd4;
        wr(3'd4, 16'd0);

        // R5 up mode and R10 output rule
        cur_req = "R5";
        wr(3'd0, ctl(0, 0, 0));
        repeat (25) @(negedge clk);
        wait_val(16'd9);
        wait_change(k);
        check("R5 wrap to 0", int'(rd_data), 0);
        cur_req = "R10";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R10 cmpA mid level", int'(pwm_a), int'(rd_data < 16'd4));
            check("R10 cmpB above period high", int'(pwm_b), 1);
        end

        // R9 counter load
        cur_req = "R9";
        wr(3'd4, 16'd7);
        check("R9 load 7", int'(rd_data), 7);
        wr(3'd4, 16'd0);
        check("R9 load 0 restart", int'(rd_data), 0);

        // R10 zero compare holds low
        cur_req = "R10";
        wr(3'd2, 16'd0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R10 cmpA zero low", int'(pwm_a), 0);
        end
        wr(3'd2, 16'd4);

        // R6 down mode, divide 2
        cur_req = "R6";
        wr(3'd0, ctl(0, 1, 1));
        wait_val(16'd0);
        wait_change(k);
        check("R6 reload period", int'(rd_data), 9);
        check("R6 step every 2", k - 1, 2);

        // R7 up-down mode
        cur_req = "R7";
        wr(3'd0, ctl(0, 0, 2));
        wait_val(16'd9);
        wait_change(k);
        check("R7 turn at period", int'(rd_data), 8);
        wait_val(16'd0);
        wait_change(k);
        check("R7 turn at zero", int'(rd_data), 1);

        // R3/R4 divider 2*6 = 12 from a control write
        cur_req = "R4";
        wr(3'd0, ctl(0, 0, 3));
        wr(3'd4, 16'd0);
        wr(3'd1, 16'd1000);
        wr(3'd2, 16'd500);
        wr(3'd0, ctl(1, 3, 0));
        wait_change(k);
        check("R4 first tick after ctrl write", k - 1, ratio(1, 3));
        check("R4 first value", int'(rd_data), 1);
        cur_req = "R3";
        wait_change(k);
        check("R3 tick interval", k - 1, ratio(1, 3));

        // R8 freeze holds counter and outputs
        cur_req = "R8";
        repeat (40) @(negedge clk);
        wr(3'd0, ctl(1, 3, 3));
        v = rd_data; ha = pwm_a; hb = pwm_b;
        repeat (60) @(negedge clk);
        check("R8 counter held", int'(rd_data), int'(v));
        check("R8 pwm_a held", int'(pwm_a), int'(ha));
        check("R8 pwm_b held", int'(pwm_b), int'(hb));
        wr(3'd0, ctl(0, 0, 0));
        @(negedge clk);
        check("R8 resume from held value", int'(rd_data), int'(v) + 1);

        // R3 largest divider 128*14
        cur_req = "R3";
        wr(3'd0, ctl(0, 0, 3));
        wr(3'd1, 16'd3);
        wr(3'd4, 16'd0);
        wr(3'd0, ctl(7, 7, 0));
        wait_change(k);
        check("R3 max divider", k - 1, ratio(7, 7));
        repeat (3 * 1792 + 20) @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule